// File: doc/BRIEF.md
# Serial Memory Write Guard with Status Byte

This block owns the status byte of a serial nonvolatile memory and decides, one request at a time, whether a pending write may go ahead. A write is either an array write, tagged with its start address, or a status-byte write carrying a new configuration byte. The decision combines four inputs: the write-enable latch, the level of the hardware write-protect pin, the lock-enable configuration bit, and the two region-lock bits that fence off an upper part of the address space.

A granted write starts a self-timed busy window. The busy flag is visible in the status byte. When the window ends, the write-enable latch clears, and a granted status write commits its new configuration. Once the lock-enable bit is set and the protect pin is low, the status byte is frozen like a programmable ROM. A status write that was already granted still commits, even if the pin falls during its busy window. The serial shifter and the array storage sit outside this block. The configuration bits are held in registers that take fixed values at reset.

Top module: `blk_write_guard`

## Requirements
- R1: After reset, status_o reads 0x60. Bit 7 is lock enable = 0, bits 6:5 are the watchdog select = 11, bit 4 is the startup-delay select = 0, bits 3:2 are the region lock = 00, bit 1 is the write-enable latch = 0 and bit 0 is busy = 0. The separate configuration outputs show the same fields.
- R2: A pulse on wel_set_i sets status bit 1 at the next clock. A pulse on wel_clr_i clears it. When both arrive together, clear wins.
- R3: No request is granted while status bit 1 is 0.
- R4: A status write (req_kind_i = 1) is refused when lock enable is 1 and wp_i is low. It is granted when lock enable is 0 or wp_i is high.
- R5: An array write (req_kind_i = 0) is refused when its 15-bit start address lies in the locked region. Region lock 00 locks nothing, 01 locks 0x6000–0x7FFF, 10 locks 0x4000–0x7FFF and 11 locks all addresses. A refused page write commits nothing.
- R6: An array write to an unlocked address needs only the latch. wp_i and lock enable have no effect on it.
- R7: grant_o pulses in the cycle after the request. Status bit 0 rises in that same cycle and stays high for WR_CYC cycles.
- R8: When the busy window ends, the latch clears in the same cycle as busy falls. A granted status write makes bits 7:2 of its data take effect at that moment. Bits 1:0 of the written data are ignored.
- R9: A granted status write still commits if wp_i falls low during its busy window. After that, if it set lock enable, further status writes with wp_i low are refused.
- R10: While busy is high, requests and latch strobes are ignored.
- R11: A refused request leaves the latch and the configuration unchanged and starts no busy window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wel_set_i | input | 1 | Write-enable latch set strobe |
| wel_clr_i | input | 1 | Write-enable latch clear strobe |
| req_valid_i | input | 1 | Write request present this cycle |
| req_kind_i | input | 1 | 0 = array write, 1 = status write |
| req_addr_i | input | 15 | Array start address |
| req_data_i | input | 8 | Data byte for a status write |
| wp_i | input | 1 | Write-protect pin level, low = protect |
| grant_o | output | 1 | One-cycle grant pulse |
| status_o | output | 8 | Status byte |
| lock_en_o | output | 1 | Lock-enable configuration bit |
| wd_sel_o | output | 2 | Watchdog period select |
| pup_sel_o | output | 1 | Startup-delay select |
| region_o | output | 2 | Region-lock field |

## Verification
A corrupted latch shows up at grant_o on the very next request. It can show as a grant with the latch cleared, or as a legal write that is refused. The same fault is visible in status bit 1 one cycle after the strobe that should have changed it. A wrong region decode or a wrong lock-enable and pin term shows in the grant pulse one cycle after the request. A mistimed busy counter, or a commit of the wrong data, shows in status bits 0 and 7:2 exactly WR_CYC cycles after the grant. So every internal fault reaches the ports within one busy window.

// File: rtl/blk_guard_pkg.sv
// Shared types for the write guard: request kinds and the configuration
// field layout of status bits 7:2, with its reset value.
package blk_guard_pkg;

    typedef enum logic {
        REQ_ARRAY  = 1'b0,
        REQ_STATUS = 1'b1
    } req_kind_e;

    // Field order matches status bits 7:2 (MSB first).
    typedef struct packed {
        logic       lock_en;
        logic [1:0] wd_sel;
        logic       pup_sel;
        logic [1:0] region;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{lock_en: 1'b0, wd_sel: 2'b11,
                                   pup_sel: 1'b0, region: 2'b00};

endpackage

// File: rtl/blk_guard_region.sv
// Region decoder: flags an address that lies inside the locked upper part
// of the space. Assumes ADDR_W >= 2. Lock codes are 00 none, 01 top quarter,
// 10 top half and 11 whole space.
module blk_guard_region #(
    parameter int ADDR_W = 15
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        region_i,
    output logic              locked_o
);
    localparam int TOP = ADDR_W - 1;

    // Compare the top address bits against the selected fence.
    always_comb begin
        case (region_i)
            2'b00:   locked_o = 1'b0;
            2'b01:   locked_o = &addr_i[TOP -: 2];
            2'b10:   locked_o = addr_i[TOP];
            default: locked_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/blk_guard_policy.sv
// Grant policy: the combinational decision whether the request seen this
// cycle may start a nonvolatile write. Assumes all inputs are already
// registered state or stable request fields.
module blk_guard_policy
    import blk_guard_pkg::*;
(
    input  logic      valid_i,
    input  req_kind_e kind_i,
    input  logic      locked_i,
    input  logic      wel_i,
    input  logic      busy_i,
    input  logic      lock_en_i,
    input  logic      wp_i,
    output logic      allow_o
);
    logic kind_ok;

    // Pick the check that applies to this kind of write.
    always_comb begin
        if (kind_i == REQ_STATUS) kind_ok = !(lock_en_i && !wp_i);
        else                      kind_ok = !locked_i;
    end

    // A grant needs a request, the latch set, an idle engine and the per-kind check.
    always_comb allow_o = valid_i && wel_i && !busy_i && kind_ok;
endmodule

// File: rtl/blk_guard_timer.sv
// Busy timer: holds busy for WR_CYC cycles after a start pulse and flags the
// last busy cycle with done_o. Assumes start_i never arrives while busy.
module blk_guard_timer #(
    parameter int WR_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic done_o
);
    localparam int CNT_W = (WR_CYC > 1) ? $clog2(WR_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WR_CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    // Load on start, count down while busy, drop busy after the last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o <= 1'b0;
            cnt_q  <= '0;
        end else if (start_i) begin
            busy_o <= 1'b1;
            cnt_q  <= CNT_LOAD;
        end else if (busy_o) begin
            if (cnt_q == '0) busy_o <= 1'b0;
            else             cnt_q  <= cnt_q - 1'b1;
        end
    end

    // Last busy cycle marker.
    always_comb done_o = busy_o && (cnt_q == '0);
endmodule

// File: rtl/blk_write_guard.sv
// Write guard top: holds the configuration bits and the write-enable latch,
// grants array and status writes through the policy, and commits a status
// write when its busy window ends. Assumes the request fields are valid
// in the cycle in which req_valid_i is high.
module blk_write_guard
    import blk_guard_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int WR_CYC = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wel_set_i,
    input  logic              wel_clr_i,
    input  logic              req_valid_i,
    input  logic              req_kind_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [7:0]        req_data_i,
    input  logic              wp_i,
    output logic              grant_o,
    output logic [7:0]        status_o,
    output logic              lock_en_o,
    output logic [1:0]        wd_sel_o,
    output logic              pup_sel_o,
    output logic [1:0]        region_o
);
    cfg_t      cfg_q;
    cfg_t      pend_q;
    req_kind_e kind_q;
    logic      wel_q;
    logic      grant_q;
    logic      locked;
    logic      allow;
    logic      busy;
    logic      done;

    blk_guard_region #(.ADDR_W(ADDR_W)) u_region (
        .addr_i   (req_addr_i),
        .region_i (cfg_q.region),
        .locked_o (locked)
    );

    blk_guard_policy u_policy (
        .valid_i   (req_valid_i),
        .kind_i    (req_kind_e'(req_kind_i)),
        .locked_i  (locked),
        .wel_i     (wel_q),
        .busy_i    (busy),
        .lock_en_i (cfg_q.lock_en),
        .wp_i      (wp_i),
        .allow_o   (allow)
    );

    blk_guard_timer #(.WR_CYC(WR_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (allow),
        .busy_o  (busy),
        .done_o  (done)
    );

    // Register the grant and capture what the granted write will commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_q <= 1'b0;
            kind_q  <= REQ_ARRAY;
            pend_q  <= CFG_RESET;
        end else begin
            grant_q <= allow;
            if (allow) begin
                kind_q <= req_kind_e'(req_kind_i);
                pend_q <= cfg_t'(req_data_i[7:2]);
            end
        end
    end

    // Latch and configuration update: commit at the end of the busy window, strobes only when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wel_q <= 1'b0;
            cfg_q <= CFG_RESET;
        end else if (done) begin
            wel_q <= 1'b0;
            if (kind_q == REQ_STATUS) cfg_q <= pend_q;
        end else if (!busy) begin
            if (wel_clr_i)      wel_q <= 1'b0;
            else if (wel_set_i) wel_q <= 1'b1;
        end
    end

    // Output assembly.
    always_comb begin
        grant_o   = grant_q;
        status_o  = {cfg_q, wel_q, busy};
        lock_en_o = cfg_q.lock_en;
        wd_sel_o  = cfg_q.wd_sel;
        pup_sel_o = cfg_q.pup_sel;
        region_o  = cfg_q.region;
    end

    AST_NO_GRANT_WO_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        grant_q |-> $past(wel_q));                                           // R3
    AST_ROM_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_q && kind_q == REQ_STATUS) |-> !$past(cfg_q.lock_en && !wp_i)); // R4
    AST_LOCKED_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_q && kind_q == REQ_ARRAY) |-> !$past(locked));                 // R5
    AST_BUSY_ON_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        grant_q |-> busy);                                                   // R7
    AST_WEL_DROP_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !wel_q);                                             // R8
    AST_NO_GRANT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        grant_q |-> !$past(busy));                                           // R10
    AST_CFG_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_q) |-> $fell(busy));                                    // R11
endmodule

// File: tb/blk_write_guard_bench.sv
`timescale 1ns/1ps
module blk_write_guard_bench;
    localparam int AW = 15;
    localparam int WR = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wel_set_i = 1'b0, wel_clr_i = 1'b0;
    logic          req_valid_i = 1'b0, req_kind_i = 1'b0;
    logic [AW-1:0] req_addr_i = '0;
    logic [7:0]    req_data_i = '0;
    logic          wp_i = 1'b1;
    logic          grant_o;
    logic [7:0]    status_o;
    logic          lock_en_o, pup_sel_o;
    logic [1:0]    wd_sel_o, region_o;

    int total = 0;
    int bad   = 0;

    // reference model state
    logic       m_wel = 1'b0, m_busy = 1'b0, m_kind = 1'b0;
    logic [5:0] m_cfg = 6'b011000;
    logic [5:0] m_pend = '0;
    int         m_cnt = 0;
    logic       m_wp = 1'b1;

    blk_write_guard #(.ADDR_W(AW), .WR_CYC(WR)) u_blk_write_guard (
        .clk(clk), .rst_n(rst_n), .wel_set_i(wel_set_i), .wel_clr_i(wel_clr_i),
        .req_valid_i(req_valid_i), .req_kind_i(req_kind_i), .req_addr_i(req_addr_i),
        .req_data_i(req_data_i), .wp_i(wp_i), .grant_o(grant_o), .status_o(status_o),
        .lock_en_o(lock_en_o), .wd_sel_o(wd_sel_o), .pup_sel_o(pup_sel_o),
        .region_o(region_o)
    );

    always #2 clk = ~clk;

    function automatic logic in_lock(input logic [AW-1:0] a, input logic [1:0] r);
        case (r)
            2'b00:   return 1'b0;
            2'b01:   return a >= 15'h6000;
            2'b10:   return a >= 15'h4000;
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic [7:0] m_status();
        return {m_cfg, m_wel, m_busy};
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // One cycle: drive at negedge, advance model, sample at next negedge.
    task automatic step(input string tag, input logic s, input logic c, input logic v,
                        input logic k, input logic [AW-1:0] a, input logic [7:0] d,
                        input logic w);
        logic g;
        wel_set_i = s; wel_clr_i = c; req_valid_i = v; req_kind_i = k;
        req_addr_i = a; req_data_i = d; wp_i = w; m_wp = w;
        g = v && m_wel && !m_busy && (k ? !(m_cfg[5] && !w) : !in_lock(a, m_cfg[1:0]));
        if (m_busy) begin
            if (m_cnt == 0) begin
                m_busy = 1'b0; m_wel = 1'b0;
                if (m_kind) m_cfg = m_pend;
            end else m_cnt--;
        end else begin
            if (g) begin m_busy = 1'b1; m_cnt = WR - 1; m_kind = k; m_pend = d[7:2]; end
            if (c) m_wel = 1'b0;
            else if (s) m_wel = 1'b1;
        end
        @(posedge clk);
        @(negedge clk);
        chk({tag, " grant"}, {7'd0, grant_o}, {7'd0, g});
        chk({tag, " status"}, status_o, m_status());
        chk({tag, " cfg"}, {2'b0, lock_en_o, wd_sel_o, pup_sel_o, region_o}, {2'b0, m_cfg});
    endtask

    task automatic idle(input string tag, input int n);
        for (int i = 0; i < n; i++) step(tag, 0, 0, 0, 0, '0, '0, m_wp);
    endtask

    task automatic wren(input string tag);
        step(tag, 1, 0, 0, 0, '0, '0, m_wp);
    endtask

    task automatic sr_write(input string tag, input logic [7:0] d);
        wren(tag);
        step(tag, 0, 0, 1, 1, '0, d, m_wp);
        idle(tag, WR + 1);
    endtask

    task automatic arr_write(input string tag, input logic [AW-1:0] a);
        wren(tag);
        step(tag, 0, 0, 1, 0, a, 8'hA5, m_wp);
        idle(tag, WR + 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240517));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 status", status_o, 8'h60);
        chk("R1 cfg", {2'b0, lock_en_o, wd_sel_o, pup_sel_o, region_o}, 8'h18);
        chk("R1 grant", {7'd0, grant_o}, 8'h00);
        // R3: request with latch clear
        step("R3", 0, 0, 1, 0, 15'h0010, '0, 1);
        step("R3", 0, 0, 1, 1, '0, 8'hFF, 1);
        // R2: set, clear, both together
        step("R2", 1, 0, 0, 0, '0, '0, 1);
        step("R2", 0, 1, 0, 0, '0, '0, 1);
        step("R2", 1, 1, 0, 0, '0, '0, 1);
        // R6/R7/R8: array write with no lock, busy window and latch drop
        arr_write("R7", 15'h7FFF);
        // R8: status write, low two data bits ignored, region 01
        sr_write("R8", 8'h57);
        // R5: region 01 fence edges; R11 refused request keeps latch
        wren("R5");
        step("R11", 0, 0, 1, 0, 15'h6000, '0, 1);
        step("R5", 0, 0, 1, 0, 15'h5FFF, '0, 1);
        idle("R5", WR + 1);
        sr_write("R5", 8'h08);
        arr_write("R5", 15'h4000);
        arr_write("R5", 15'h3FFF);
        sr_write("R5", 8'h0C);
        arr_write("R5", 15'h0000);
        // R9: lock enable granted, pin falls mid-window, write completes
        wren("R9");
        step("R9", 0, 0, 1, 1, '0, 8'h80, 1);
        idle("R9", 2);
        m_wp = 1'b0;
        idle("R9", WR);
        // R4: frozen status byte with pin low
        wren("R4");
        step("R4", 0, 0, 1, 1, '0, 8'h60, 0);
        // R6: array write unaffected by pin and lock enable
        step("R6", 0, 0, 1, 0, 15'h7000, '0, 0);
        // R10: strobes and requests during busy are ignored
        step("R10", 1, 1, 1, 1, '0, 8'hFC, 0);
        step("R10", 1, 0, 1, 0, 15'h0001, '0, 0);
        idle("R10", WR);
        // R4: pin high reopens status writes
        m_wp = 1'b1;
        sr_write("R4", 8'h60);
        // random mix
        for (int i = 0; i < 4000; i++) begin
            logic s, c, v, k, w;
            s = ($urandom_range(0, 99) < 35);
            c = ($urandom_range(0, 99) < 8);
            v = ($urandom_range(0, 99) < 40);
            k = ($urandom_range(0, 99) < 30);
            w = ($urandom_range(0, 99) < 70);
            step("R5/R7 random", s, c, v, k, AW'($urandom), 8'($urandom), w);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule